// File: doc/BRIEF.md
# Keyboard Scan-Code Event Decoder

This block sits behind a keyboard serial receiver. It takes the received bytes one at a time and folds each complete key sequence into one key event. An event carries a base code, an extended flag and a break (release) flag.

Prefix bytes are remembered between bytes and produce no output. The multi-byte pause sequence is matched byte by byte and becomes a single event. Bytes that report device status go to a separate status output. A mode input switches from the default code set, where release is signalled by a prefix, to the older code set, where release is signalled by the top bit of the code.

Inputs arrive as a valid/byte pair. Each output is a valid pulse one cycle long, registered one clock after the byte that completes it.

Top module: `scan_event_decoder`

## Requirements
- R1: While reset is asserted and at the first clock after release, `ev_valid` and `st_valid` are both low.
- R2: In the default set (`set1_mode`=0), a plain code byte with no prefix pending gives `ev_valid`=1 on the next cycle, with `ev_code` equal to the byte and `ev_ext`=0, `ev_brk`=0, `ev_pause`=0. No byte ever raises both outputs.
- R3: In the default set, byte F0h is a release prefix and gives no output. The next code byte gives an event with `ev_brk`=1.
- R4: Byte E0h is an extended prefix and gives no output. The next code gives `ev_ext`=1. The sequence E0h F0h code gives `ev_ext`=1 and `ev_brk`=1.
- R5: Both prefix flags are cleared once an event is emitted, so the next code byte is decoded as a plain press.
- R6: In the default set, the bytes E1 14 77 E1 F0 14 F0 77 (hex) produce exactly one event, on the last byte. That event has `ev_pause`=1, `ev_code`=PAUSE_CODE and `ev_ext`=`ev_brk`=0. The earlier bytes produce nothing.
- R7: A byte that does not match the next expected pause byte abandons the pause match. That byte is then decoded as if it had just arrived with no prefix pending (an E1h restarts the match).
- R8: With no prefix pending, the bytes 00h, FAh, FEh and FCh (and AAh in the default set) give `st_valid`=1 with `st_code` equal to the byte, and no event. With a prefix pending, these bytes are decoded as key codes.
- R9: In the old set (`set1_mode`=1), F0h is an ordinary code. An event has `ev_brk` equal to bit 7 of the byte and `ev_code` equal to bits 6:0 of the byte with bit 7 cleared. E0h still marks extended.
- R10: In the old set, the pause sequence is E1 1D 45 E1 9D C5 (hex). AAh is decoded as a key code (the release of 2Ah), not as status.
- R11: The same press code repeated with no release gives one press event per byte.
- R12: Cycles with `in_valid` low produce no output. Each output pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set1_mode | input | 1 | 1 selects old-set decoding (top bit means release) |
| in_valid | input | 1 | A received byte is present this cycle |
| in_byte | input | 8 | Received byte |
| ev_valid | output | 1 | One-cycle key event strobe |
| ev_pause | output | 1 | Event is the collapsed pause key |
| ev_ext | output | 1 | Event carried the extended prefix |
| ev_brk | output | 1 | Event is a key release |
| ev_code | output | 8 | Base key code |
| st_valid | output | 1 | One-cycle status byte strobe |
| st_code | output | 8 | Status byte value |

## Verification
The bench builds the decoder with PAUSE_CODE overridden to 7Fh. This makes the pause event's code differ from the reset value of the code register, so a pause event that drops its code field is caught. No other parameter changes the decode paths. Directed sequences cover release and extended prefixes, pause matches aborted at several positions, and status bytes with and without a pending prefix, in both code sets. A long run of bytes drawn mostly from the prefix, pause and status values then exercises the orderings between them.

// File: rtl/scan_event_decoder.sv
module scan_event_decoder #(
  parameter logic [7:0] PAUSE_CODE = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set1_mode,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       ev_valid,
  output logic       ev_pause,
  output logic       ev_ext,
  output logic       ev_brk,
  output logic [7:0] ev_code,
  output logic       st_valid,
  output logic [7:0] st_code
);
  localparam logic [2:0] LAST_IDX_SET2 = 3'd7;
  localparam logic [2:0] LAST_IDX_SET1 = 3'd5;

  function automatic logic [7:0] pause_byte(input logic s1, input logic [2:0] i);
    if (s1) begin
      case (i)
        3'd1: pause_byte = 8'h1D;
        3'd2: pause_byte = 8'h45;
        3'd3: pause_byte = 8'hE1;
        3'd4: pause_byte = 8'h9D;
        3'd5: pause_byte = 8'hC5;
        default: pause_byte = 8'hE1;
      endcase
    end else begin
      case (i)
        3'd1: pause_byte = 8'h14;
        3'd2: pause_byte = 8'h77;
        3'd3: pause_byte = 8'hE1;
        3'd4: pause_byte = 8'hF0;
        3'd5: pause_byte = 8'h14;
        3'd6: pause_byte = 8'hF0;
        3'd7: pause_byte = 8'h77;
        default: pause_byte = 8'hE1;
      endcase
    end
  endfunction

  logic       pend_e0, pend_f0;
  logic [2:0] pidx;

  wire in_pause   = pidx != 3'd0;
  wire pause_hit  = in_pause && in_byte == pause_byte(set1_mode, pidx);
  wire pause_last = pause_hit && pidx == (set1_mode ? LAST_IDX_SET1 : LAST_IDX_SET2);
  wire is_e1      = in_byte == 8'hE1;
  wire is_e0      = in_byte == 8'hE0;
  wire is_f0      = !set1_mode && in_byte == 8'hF0;
  wire stat_val   = in_byte == 8'h00 || in_byte == 8'hFA || in_byte == 8'hFE ||
                    in_byte == 8'hFC || (!set1_mode && in_byte == 8'hAA);
  wire is_status  = stat_val && !pend_e0 && !pend_f0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_e0  <= 1'b0;
      pend_f0  <= 1'b0;
      pidx     <= 3'd0;
      ev_valid <= 1'b0;
      ev_pause <= 1'b0;
      ev_ext   <= 1'b0;
      ev_brk   <= 1'b0;
      ev_code  <= 8'h00;
      st_valid <= 1'b0;
      st_code  <= 8'h00;
    end else begin
      ev_valid <= 1'b0;
      st_valid <= 1'b0;
      if (in_valid) begin
        if (pause_hit) begin
          pidx <= pause_last ? 3'd0 : pidx + 3'd1;
          if (pause_last) begin
            ev_valid <= 1'b1;
            ev_pause <= 1'b1;
            ev_ext   <= 1'b0;
            ev_brk   <= 1'b0;
            ev_code  <= PAUSE_CODE;
          end
        end else begin
          pidx <= 3'd0;
          if (is_e1) begin
            pidx    <= 3'd1;
            pend_e0 <= 1'b0;
            pend_f0 <= 1'b0;
          end else if (is_e0) begin
            pend_e0 <= 1'b1;
          end else if (is_f0) begin
            pend_f0 <= 1'b1;
          end else if (is_status) begin
            st_valid <= 1'b1;
            st_code  <= in_byte;
          end else begin
            ev_valid <= 1'b1;
            ev_pause <= 1'b0;
            ev_ext   <= pend_e0;
            ev_brk   <= set1_mode ? in_byte[7] : pend_f0;
            ev_code  <= set1_mode ? {1'b0, in_byte[6:0]} : in_byte;
            pend_e0  <= 1'b0;
            pend_f0  <= 1'b0;
          end
        end
      end
    end
  end

  p_one_output_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_valid && st_valid));
  p_event_needs_byte_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> $past(in_valid));
  p_status_no_prefix_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> $past(in_valid) && !$past(pend_e0) && !$past(pend_f0));
  p_set1_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_pause && $past(set1_mode) |-> !ev_code[7]);
  p_pause_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_pause |-> !ev_ext && !ev_brk);
  p_prefix_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> !pend_e0 && !pend_f0);
  p_pause_no_prefix_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pidx != 3'd0 |-> !pend_e0 && !pend_f0);
endmodule

// File: tb/test_scan_event_decoder.sv
module test_scan_event_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set1_mode = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic ev_valid, ev_pause, ev_ext, ev_brk, st_valid;
  logic [7:0] ev_code, st_code;

  localparam logic [7:0] PCODE = 8'h7F;

  scan_event_decoder #(.PAUSE_CODE(PCODE)) i_scan_event_decoder (
    .clk(clk), .rst_n(rst_n), .set1_mode(set1_mode), .in_valid(in_valid),
    .in_byte(in_byte), .ev_valid(ev_valid), .ev_pause(ev_pause), .ev_ext(ev_ext),
    .ev_brk(ev_brk), .ev_code(ev_code), .st_valid(st_valid), .st_code(st_code));

  always #2 clk = ~clk;

  int vectors = 0, fails = 0, cycles = 0;
  bit e0 = 0, f0 = 0;
  logic [7:0] pq[$];
  bit x_ev, x_pause, x_ext, x_brk, x_st;
  logic [7:0] x_code, x_scode;
  string tag = "R1";

  task automatic decode(input logic [7:0] b, input bit s1);
    bit aborted = 0;
    if (pq.size() > 0) begin
      if (b == pq[0]) begin
        void'(pq.pop_front());
        tag = s1 ? "R10" : "R6";
        if (pq.size() == 0) begin
          x_ev = 1; x_pause = 1; x_ext = 0; x_brk = 0; x_code = PCODE;
        end
        return;
      end
      pq.delete();
      aborted = 1;
    end
    if (b == 8'hE1) begin
      if (s1) pq = '{8'h1D, 8'h45, 8'hE1, 8'h9D, 8'hC5};
      else    pq = '{8'h14, 8'h77, 8'hE1, 8'hF0, 8'h14, 8'hF0, 8'h77};
      e0 = 0; f0 = 0;
      tag = aborted ? "R7" : (s1 ? "R10" : "R6");
      return;
    end
    if (b == 8'hE0) begin e0 = 1; tag = aborted ? "R7" : "R4"; return; end
    if (!s1 && b == 8'hF0) begin f0 = 1; tag = aborted ? "R7" : "R3"; return; end
    if (!e0 && !f0 && (b == 8'h00 || b == 8'hFA || b == 8'hFE || b == 8'hFC ||
                       (!s1 && b == 8'hAA))) begin
      x_st = 1; x_scode = b; tag = aborted ? "R7" : "R8";
      return;
    end
    x_ev = 1; x_pause = 0; x_ext = e0;
    x_brk = s1 ? b[7] : f0;
    x_code = s1 ? {1'b0, b[6:0]} : b;
    if (aborted) tag = "R7";
    else if (s1) tag = "R9";
    else if (e0) tag = "R4";
    else if (f0) tag = "R3";
    else tag = "R2";
    e0 = 0; f0 = 0;
  endtask

  always @(posedge clk) begin
    x_ev = 0; x_st = 0;
    if (!rst_n) begin
      e0 = 0; f0 = 0; pq.delete(); tag = "R1";
    end else begin
      tag = "R12";
      if (in_valid) decode(in_byte, set1_mode);
    end
  end

  always @(negedge clk) begin
    vectors++;
    if (ev_valid !== x_ev || st_valid !== x_st ||
        (x_ev && (ev_pause !== x_pause || ev_ext !== x_ext || ev_brk !== x_brk ||
                  ev_code !== x_code)) ||
        (x_st && st_code !== x_scode)) begin
      fails++;
      $display("FAIL %s: got ev=%b p=%b x=%b b=%b c=%h st=%b s=%h exp ev=%b p=%b x=%b b=%b c=%h st=%b s=%h",
               tag, ev_valid, ev_pause, ev_ext, ev_brk, ev_code, st_valid, st_code,
               x_ev, x_pause, x_ext, x_brk, x_code, x_st, x_scode);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL R12: watchdog expired, got cycles=%0d expected below 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic send(input logic [7:0] b, input bit gap);
    @(negedge clk);
    in_valid = 1; in_byte = b;
    if (gap) begin
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic seq(input logic [7:0] b[], input bit gap);
    foreach (b[i]) send(b[i], gap);
    idle(1);
  endtask

  logic [7:0] pool[] = '{8'hE0, 8'hF0, 8'hE1, 8'h14, 8'h77, 8'h1D, 8'h45, 8'h9D,
                         8'hC5, 8'hAA, 8'hFA, 8'hFE, 8'hFC, 8'h00, 8'h1C, 8'h75};

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    idle(2);
    // default set: press, release, extended, repeat (R2 R3 R4 R5 R11)
    seq('{8'h1C}, 1);
    seq('{8'hF0, 8'h1C}, 0);
    seq('{8'hE0, 8'h75, 8'h75}, 0);
    seq('{8'hE0, 8'hF0, 8'h75, 8'h1C}, 1);
    seq('{8'h1C, 8'h1C, 8'h1C}, 0);
    // pause and its aborts (R6 R7)
    seq('{8'hE1, 8'h14, 8'h77, 8'hE1, 8'hF0, 8'h14, 8'hF0, 8'h77}, 0);
    seq('{8'hE1, 8'h14, 8'h77, 8'hE1, 8'hF0, 8'h14, 8'hF0, 8'h77}, 1);
    seq('{8'hE1, 8'h14, 8'h1C}, 0);
    seq('{8'hE1, 8'h14, 8'h77, 8'hE1, 8'hE0, 8'h75}, 0);
    seq('{8'hE1, 8'hE1, 8'h14, 8'h77, 8'hE1, 8'hF0, 8'h14, 8'hF0, 8'h77}, 0);
    seq('{8'hE1, 8'h14, 8'h77, 8'hE1, 8'hF0, 8'hFA}, 0);
    // status (R8)
    seq('{8'hAA, 8'hFA, 8'hFE, 8'hFC, 8'h00}, 0);
    seq('{8'hF0, 8'hAA, 8'hE0, 8'hFA}, 0);
    seq('{8'h1C}, 0);
    // old set (R9 R10)
    set1_mode = 1;
    seq('{8'h1D, 8'h9D, 8'hE0, 8'h48, 8'hE0, 8'hC8, 8'hF0, 8'hAA, 8'hFA}, 0);
    seq('{8'hE1, 8'h1D, 8'h45, 8'hE1, 8'h9D, 8'hC5}, 1);
    seq('{8'hE1, 8'h1D, 8'h1C, 8'h1E, 8'h1E}, 0);
    seq('{8'h1C}, 0);
    // mixed byte runs in both sets
    for (int m = 0; m < 2; m++) begin
      set1_mode = m[0];
      for (int k = 0; k < 3000; k++) begin
        logic [7:0] b;
        b = ($urandom % 4 != 0) ? pool[$urandom % pool.size()] : 8'($urandom);
        send(b, ($urandom % 3) == 0);
      end
      seq('{8'h1C}, 0);
    end
    idle(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule